// File: doc/BRIEF.md
# Field Select Gain Output Stage

This stage sits at the tail of a convolution datapath. It receives a wide signed accumulation result together with a valid strobe, narrows it to a 20-bit window chosen by a small select code, multiplies that window by a power of two from zero to four, and returns the upper sixteen bits of the scaled window as the output sample.

When the chosen gain pushes significant magnitude out of the top of the window, the stage flags the sample as overflowed. It also clamps the data to the largest positive or most negative 16-bit value, matching the sign of the window. The result is registered once. The output strobe therefore trails the input strobe by a single clock, and the registered sample is held until the next valid input arrives.

Top module: `fsg_output_stage`

## Requirements
- R1: With select code 00 and gain code 0, the window is result bits 19:0 and out_data equals result bits 19:4 one clock after a valid input.
- R2: Select code 01 takes the window from result bits 23:4; at gain code 0, out_data equals result bits 23:8.
- R3: Select codes 10 and 11 give the same output as code 00.
- R4: Gain code g from 0 to 4 scales the 20-bit signed window by 2^g. Without overflow, out_data is bits 19:4 of the scaled window.
- R5: Gain codes 5, 6 and 7 behave exactly like gain code 4.
- R6: out_ovf is high when the scaled window no longer fits in a signed 20-bit value, meaning a bit shifted out of the top differs from the window sign bit. Otherwise it is low.
- R7: On overflow, out_data is 16'h7FFF for a non-negative window and 16'h8000 for a negative window.
- R8: out_valid equals in_valid delayed by one clock.
- R9: While in_valid is low, out_data and out_ovf keep their previous values.
- R10: While rst is high, out_valid, out_data and out_ovf are cleared to zero on each clock edge.
- R11: Gain code 0 never produces overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| in_result | input | 32 | Signed convolution result |
| in_fsel | input | 2 | Window select code (01 upper window, others lower window) |
| in_gain | input | 3 | Gain code, left shift 0..4, codes above 4 clamp to 4 |
| out_valid | output | 1 | Output strobe, in_valid delayed one clock |
| out_data | output | 16 | Scaled, saturated output sample |
| out_ovf | output | 1 | Overflow flag for the current sample |

## Verification
Directed results are applied whose lower and upper windows carry different bit patterns. Under that stimulus, a wrong window position or a reserved select code that reaches the upper window shows up as a data mismatch. Values just inside and just outside the signed 20-bit range, at each gain, separate a correct overflow boundary from an off-by-one shift. Negative and positive windows separate the two saturation values. Seeded random results, with all select and gain codes and a random valid pattern, cover the general scaling path and the hold behaviour between samples.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

    localparam int RES_W      = 32;
    localparam int FIELD_W    = 20;
    localparam int OUT_W      = 16;
    localparam int FIELD_STEP = 4;
    localparam int MAX_GAIN   = 4;
    localparam int GAIN_W     = 3;
    localparam int FSEL_W     = 2;
    localparam int NUM_FIELDS = 2;

    typedef enum logic [FSEL_W-1:0] {
        FSEL_LOWER = 2'b00,
        FSEL_UPPER = 2'b01,
        FSEL_RSV_A = 2'b10,
        FSEL_RSV_B = 2'b11
    } fsel_e;

    typedef struct packed {
        logic             ovf;
        logic [OUT_W-1:0] data;
    } stage_word_t;

    // Saturation value for a window of the given sign.
    function automatic logic [OUT_W-1:0] sat_word(input logic neg);
        logic [OUT_W-1:0] w;
        w = '0;
        w[OUT_W-1] = neg;
        for (int i = 0; i < OUT_W - 1; i++) begin
            w[i] = ~neg;
        end
        return w;
    endfunction

    // Window index chosen by a select code; reserved codes map to the lower window.
    function automatic logic window_index(input fsel_e code);
        return (code == FSEL_UPPER);
    endfunction

endpackage

// File: rtl/fsg_field_mux.sv
module fsg_field_mux
    import fsg_pkg::*;
#(
    parameter int P_RES_W   = RES_W,
    parameter int P_FIELD_W = FIELD_W,
    parameter int P_STEP    = FIELD_STEP,
    parameter int P_NUM     = NUM_FIELDS
) (
    input  logic [P_RES_W-1:0]   result,
    input  logic [FSEL_W-1:0]    fsel,
    output logic [P_FIELD_W-1:0] field
);

    localparam int IDX_W = (P_NUM > 1) ? $clog2(P_NUM) : 1;

    logic [P_FIELD_W-1:0] windows [P_NUM];
    logic [IDX_W-1:0]     idx;

    for (genvar k = 0; k < P_NUM; k++) begin : g_window
        assign windows[k] = result[k*P_STEP +: P_FIELD_W];
    end

    always_comb begin
        idx   = IDX_W'(window_index(fsel_e'(fsel)));
        field = windows[idx];
    end

endmodule

// File: rtl/fsg_gain_shift.sv
module fsg_gain_shift
    import fsg_pkg::*;
#(
    parameter int P_FIELD_W = FIELD_W,
    parameter int P_OUT_W   = OUT_W,
    parameter int P_MAX     = MAX_GAIN,
    parameter int P_GAIN_W  = GAIN_W
) (
    input  logic [P_FIELD_W-1:0] field,
    input  logic [P_GAIN_W-1:0]  gain,
    output logic [P_OUT_W-1:0]   word,
    output logic                 ovf
);

    localparam int NCAND = P_MAX + 1;
    localparam int SEL_W = (NCAND > 1) ? $clog2(NCAND) : 1;

    logic [P_OUT_W-1:0] cand_word [NCAND];
    logic [NCAND-1:0]   cand_ovf;
    logic [SEL_W-1:0]   gsel;
    logic               sign;

    assign sign = field[P_FIELD_W-1];

    // One candidate per shift amount; each checks its own spilled bits.
    for (genvar s = 0; s < NCAND; s++) begin : g_cand
        logic [P_FIELD_W-1:0] shifted;
        assign shifted      = field << s;
        assign cand_word[s] = shifted[P_FIELD_W-1 -: P_OUT_W];
        if (s == 0) begin : g_noshift
            assign cand_ovf[s] = 1'b0;
        end else begin : g_shift
            logic [s:0] top;
            assign top         = field[P_FIELD_W-1 -: s+1];
            assign cand_ovf[s] = ~((&top) | (~|top));
        end
    end

    always_comb begin
        if (int'(gain) > P_MAX) begin
            gsel = SEL_W'(P_MAX);
        end else begin
            gsel = SEL_W'(gain);
        end
        ovf  = cand_ovf[gsel];
        word = ovf ? sat_word(sign) : cand_word[gsel];
    end

endmodule

// File: rtl/fsg_out_reg.sv
module fsg_out_reg
    import fsg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        d_valid,
    input  stage_word_t d_word,
    output logic        q_valid,
    output stage_word_t q_word
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid <= 1'b0;
            q_word  <= '0;
        end else begin
            q_valid <= d_valid;
            if (d_valid) begin
                q_word <= d_word;
            end
        end
    end

endmodule

// File: rtl/fsg_output_stage.sv
module fsg_output_stage
    import fsg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [RES_W-1:0]  in_result,
    input  logic [FSEL_W-1:0] in_fsel,
    input  logic [GAIN_W-1:0] in_gain,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_data,
    output logic              out_ovf
);

    logic [FIELD_W-1:0] field;
    stage_word_t        comb_word;
    stage_word_t        reg_word;

    fsg_field_mux i_mux (
        .result (in_result),
        .fsel   (in_fsel),
        .field  (field)
    );

    fsg_gain_shift i_gain (
        .field (field),
        .gain  (in_gain),
        .word  (comb_word.data),
        .ovf   (comb_word.ovf)
    );

    fsg_out_reg i_reg (
        .clk     (clk),
        .rst     (rst),
        .d_valid (in_valid),
        .d_word  (comb_word),
        .q_valid (out_valid),
        .q_word  (reg_word)
    );

    assign out_data = reg_word.data;
    assign out_ovf  = reg_word.ovf;

endmodule

// File: rtl/fsg_output_stage_chk.sv
module fsg_output_stage_chk
    import fsg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [GAIN_W-1:0] in_gain,
    input logic              out_valid,
    input logic [OUT_W-1:0]  out_data,
    input logic              out_ovf
);

    assert_valid_delay_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_valid == $past(in_valid)));

    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(in_valid)) |-> ($stable(out_data) && $stable(out_ovf)));

    assert_sat_value_R7: assert property (@(posedge clk) disable iff (rst)
        out_ovf |-> (out_data == sat_word(1'b0) || out_data == sat_word(1'b1)));

    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid) && $past(in_gain) == '0) |-> !out_ovf);

    assert_reset_clear_R10: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && out_data == '0 && !out_ovf));

endmodule

bind fsg_output_stage fsg_output_stage_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_gain   (in_gain),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_ovf   (out_ovf)
);

// File: tb/test_fsg_output_stage.sv
`timescale 1ns/1ps
module test_fsg_output_stage;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_result = '0;
    logic [1:0]  in_fsel = '0;
    logic [2:0]  in_gain = '0;
    logic        out_valid;
    logic [15:0] out_data;
    logic        out_ovf;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic        exp_valid = 1'b0;
    logic [15:0] exp_data  = '0;
    logic        exp_ovf   = 1'b0;

    always #2.5 clk = ~clk;

    fsg_output_stage i_fsg_output_stage (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_result (in_result),
        .in_fsel   (in_fsel),
        .in_gain   (in_gain),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_ovf   (out_ovf)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic void ref_calc(input logic [31:0] r, input logic [1:0] fs,
                                     input logic [2:0] gc,
                                     output logic [15:0] d, output logic o);
        logic [19:0] f;
        longint v, p;
        int g;
        f = (fs == 2'b01) ? r[23:4] : r[19:0];
        v = f[19] ? (longint'(f) - 64'sd1048576) : longint'(f);
        g = (gc > 3'd4) ? 4 : int'(gc);
        p = v * (longint'(1) << g);
        if (p > 64'sd524287) begin
            o = 1'b1; d = 16'h7FFF;
        end else if (p < -64'sd524288) begin
            o = 1'b1; d = 16'h8000;
        end else begin
            o = 1'b0;
            p = p >>> 4;
            d = p[15:0];
        end
    endfunction

    // Called at a falling edge: drive, then check the registered result one edge later.
    task automatic step(input logic v, input logic [31:0] r, input logic [1:0] fs,
                        input logic [2:0] gc, input string tag);
        logic [15:0] d;
        logic        o;
        in_valid  = v;
        in_result = r;
        in_fsel   = fs;
        in_gain   = gc;
        exp_valid = v;
        if (v) begin
            ref_calc(r, fs, gc, d, o);
            exp_data = d;
            exp_ovf  = o;
        end
        @(negedge clk);
        chk("R8 out_valid", 32'(out_valid), 32'(exp_valid));
        chk({tag, " out_ovf (R6)"}, 32'(out_ovf), 32'(exp_ovf));
        chk({tag, exp_ovf ? " out_data (R7)" : " out_data"}, 32'(out_data), 32'(exp_data));
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd24681));
        in_result = 32'hFFFF_FFFF;
        in_valid  = 1'b1;
        repeat (3) @(negedge clk);
        // R10: reset clears outputs even with an active input
        chk("R10 out_valid", 32'(out_valid), 32'd0);
        chk("R10 out_data", 32'(out_data), 32'd0);
        chk("R10 out_ovf", 32'(out_ovf), 32'd0);
        in_valid = 1'b0;
        rst = 1'b0;

        // R1 lower window, no gain
        step(1'b1, 32'h0F0A_BCD5, 2'b00, 3'd0, "R1");
        chk("R1 direct slice", 32'(out_data), 32'h0000_ABCD);
        // R2 upper window, no gain
        step(1'b1, 32'h0F0A_BCD5, 2'b01, 3'd0, "R2");
        chk("R2 direct slice", 32'(out_data), 32'h0000_0ABC);
        // R3 reserved codes act as lower window
        step(1'b1, 32'h0F3A_1235, 2'b10, 3'd0, "R3");
        chk("R3 code 10", 32'(out_data), 32'h0000_A123);
        step(1'b1, 32'h0F3A_1235, 2'b11, 3'd0, "R3");
        chk("R3 code 11", 32'(out_data), 32'h0000_A123);
        // R4 each gain in range, small positive value
        for (int g = 0; g <= 4; g++) begin
            step(1'b1, 32'h0000_0310, 2'b00, 3'(g), "R4");
        end
        chk("R4 gain 4 result", 32'(out_data), 32'h0000_0310);
        // R5 codes above four clamp
        for (int g = 5; g <= 7; g++) begin
            step(1'b1, 32'h0000_1230, 2'b00, 3'(g), "R5");
            chk("R5 clamp to 4", 32'(out_data), 32'h0000_1230);
        end
        // R6/R7 boundaries at gain 1
        step(1'b1, 32'h0003_FFFF, 2'b00, 3'd1, "R6 fits");
        chk("R6 max positive fits", 32'(out_ovf), 32'd0);
        step(1'b1, 32'h0004_0000, 2'b00, 3'd1, "R6 pos ovf");
        chk("R7 positive saturation", 32'(out_data), 32'h0000_7FFF);
        step(1'b1, 32'h000C_0000, 2'b00, 3'd1, "R6 neg fits");
        chk("R6 min negative fits", 32'(out_ovf), 32'd0);
        step(1'b1, 32'h000B_FFFF, 2'b00, 3'd1, "R6 neg ovf");
        chk("R7 negative saturation", 32'(out_data), 32'h0000_8000);
        // R6 upper window with gain 4 overflow
        step(1'b1, 32'h0080_0000, 2'b01, 3'd4, "R6 upper");
        // R11 gain 0 with extreme values
        step(1'b1, 32'h0007_FFFF, 2'b00, 3'd0, "R11");
        chk("R11 no overflow", 32'(out_ovf), 32'd0);
        step(1'b1, 32'h0008_0000, 2'b00, 3'd0, "R11");
        chk("R11 no overflow neg", 32'(out_ovf), 32'd0);
        // R9 idle input must not disturb held outputs
        step(1'b0, 32'h1234_5678, 2'b01, 3'd3, "R9");
        chk("R9 held data", 32'(out_data), 32'h0000_8000);
        step(1'b0, 32'h0007_0000, 2'b00, 3'd4, "R9");
        chk("R9 held ovf", 32'(out_ovf), 32'd0);

        // Random mix
        for (int i = 0; i < 600; i++) begin
            logic        v;
            logic [31:0] r;
            v = ($urandom % 4) != 0;
            r = $urandom;
            if ((i % 3) == 0) r = {12'h000, r[19:0] >> ($urandom % 8)};
            step(v, r, 2'($urandom), 3'($urandom), v ? "R4 random" : "R9 random");
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule